// File: doc/BRIEF.md
# Dual-Port GPIO Register File with Flash and Sensor Pin Mapping

This block is a word-addressed register file of general-purpose I/O for two ports, called A and D. Each port has a data-out word, a data-in word and an output-enable word. The remaining words of the window are plain storage. A bus master reaches all of them through a simple register bus. Writes take effect at the clock edge. Reads are combinational from the address.

Some port bits are tied to devices on the board. Three bits of the port A data-out word drive the control strobes of a NAND flash, and the flash ready line shows up in the port A data-in word. Port D bit-bangs a serial sensor. Whenever a write to the port D data-out word changes its clock bit, the block sends the sensor a one-cycle edge event. The event carries the new clock level and the serial data bit from that write. The sensor's serial output shows up in the port D data-in word.

Top module: `gpio_ports`

## Requirements
- R1: While reset is asserted, and after it is released, every stored word reads as zero and the three flash strobes are low.
- R2: The word index is the byte address shifted right by two, so bits 1:0 of the address are ignored. A word inside the window other than the two data-in words stores the full 32-bit write and returns it on a read.
- R3: The window holds 23 words (indices 0 to 22). A write at index 23 or above changes nothing, and a read there returns zero.
- R4: A read at index 0x01 (port A data-in) returns the port A data-out word (index 0x00) ANDed with the port A output-enable word (index 0x02), with the flash ready input ORed into bit 7.
- R5: A read at index 0x11 (port D data-in) returns the port D data-out word (index 0x10) ANDed with the port D output-enable word (index 0x12), with the sensor serial output ORed into bit 4.
- R6: Writes to the two data-in indices (0x01, 0x11) have no effect on any read value.
- R7: Starting in the cycle after a write to index 0x00, the flash address-latch enable follows bit 6 of the stored word, the command-latch enable follows bit 5, and the chip enable follows bit 4.
- R8: When a write to index 0x10 carries a bit 1 that differs from the stored bit 1, `sens_edge` is high in the cycle of that write. In that cycle `sens_clk` equals the new bit 1 and `sens_sdi` equals bit 4 of the write data.
- R9: `sens_edge` is low in every other cycle, including writes to index 0x10 that keep bit 1 unchanged. Such writes still update the stored word. `sens_clk` and `sens_sdi` are zero whenever `sens_edge` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| flash_ready | input | 1 | Flash ready line |
| flash_ale | output | 1 | Flash address-latch enable |
| flash_cle | output | 1 | Flash command-latch enable |
| flash_ce | output | 1 | Flash chip enable |
| sens_sdo | input | 1 | Sensor serial output |
| sens_edge | output | 1 | One-cycle clock-edge event to the sensor |
| sens_clk | output | 1 | Clock level carried by the edge event |
| sens_sdi | output | 1 | Serial data carried by the edge event |

## Verification
On every cycle the assertions check the following:
- the edge event against a shadow copy of the port D clock bit, both when the event fires and when it stays quiet;
- the level and data the event carries;
- the strobe update that follows a port A write;
- the zero read outside the window;
- the live ready and sensor bits in the data-in reads.

The full masked values of the data-in words, the storage and readback of the plain words, the writes to the data-in indices that must be ignored, and the state after reset depend on a history of writes. Only the bench's reference model of the word array shows those, under random and directed traffic.

// File: rtl/gpio_ports_pkg.sv
package gpio_ports_pkg;
    // Word indices whose behaviour neighbouring logic depends on
    localparam int IDX_A_DOUT = 'h00;
    localparam int IDX_A_DIN  = 'h01;
    localparam int IDX_A_OE   = 'h02;
    localparam int IDX_D_DOUT = 'h10;
    localparam int IDX_D_DIN  = 'h11;
    localparam int IDX_D_OE   = 'h12;

    // Bit positions of the board wiring
    localparam int BIT_FL_READY = 7;
    localparam int BIT_FL_ALE   = 6;
    localparam int BIT_FL_CLE   = 5;
    localparam int BIT_FL_CE    = 4;
    localparam int BIT_SN_CLK   = 1;
    localparam int BIT_SN_DATA  = 4;
endpackage

// File: rtl/gpio_word_bank.sv
module gpio_word_bank
    import gpio_ports_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int NUM_WORDS = 23,
    parameter int IDX_W     = 6
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr,
    input  logic [IDX_W-1:0]                 idx,
    input  logic [DATA_W-1:0]                wdata,
    output logic [NUM_WORDS-1:0][DATA_W-1:0] words
);
    for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
        if (g == IDX_A_DIN || g == IDX_D_DIN) begin : g_virtual
            // data-in words are computed on read, never stored
            assign words[g] = '0;
        end else begin : g_store
            logic hit;
            assign hit = wr && (idx == IDX_W'(g));
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    words[g] <= '0;
                end else if (hit) begin
                    words[g] <= wdata;
                end
            end
        end
    end
endmodule

// File: rtl/gpio_read_mux.sv
module gpio_read_mux
    import gpio_ports_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int NUM_WORDS = 23,
    parameter int IDX_W     = 6
) (
    input  logic [IDX_W-1:0]                 idx,
    input  logic [NUM_WORDS-1:0][DATA_W-1:0] words,
    input  logic                             fl_ready,
    input  logic                             sn_sdo,
    output logic [DATA_W-1:0]                rdata
);
    logic [DATA_W-1:0] stored;

    always_comb begin
        stored = '0;
        for (int i = 0; i < NUM_WORDS; i++) begin
            if (idx == IDX_W'(i)) stored = words[i];
        end
    end

    always_comb begin
        if (idx == IDX_W'(IDX_A_DIN)) begin
            rdata = words[IDX_A_DOUT] & words[IDX_A_OE];
            rdata[BIT_FL_READY] = rdata[BIT_FL_READY] | fl_ready;
        end else if (idx == IDX_W'(IDX_D_DIN)) begin
            rdata = words[IDX_D_DOUT] & words[IDX_D_OE];
            rdata[BIT_SN_DATA] = rdata[BIT_SN_DATA] | sn_sdo;
        end else begin
            rdata = stored; // zero outside the window
        end
    end
endmodule

// File: rtl/gpio_periph_map.sv
module gpio_periph_map
    import gpio_ports_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 6
) (
    input  logic              wr,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] a_dout,
    input  logic [DATA_W-1:0] d_dout,
    output logic              fl_ale,
    output logic              fl_cle,
    output logic              fl_ce,
    output logic              sn_edge,
    output logic              sn_clk,
    output logic              sn_sdi
);
    assign fl_ale = a_dout[BIT_FL_ALE];
    assign fl_cle = a_dout[BIT_FL_CLE];
    assign fl_ce  = a_dout[BIT_FL_CE];

    logic d_write;
    assign d_write = wr && (idx == IDX_W'(IDX_D_DOUT));

    always_comb begin
        sn_edge = d_write && (wdata[BIT_SN_CLK] != d_dout[BIT_SN_CLK]);
        sn_clk  = sn_edge && wdata[BIT_SN_CLK];
        sn_sdi  = sn_edge && wdata[BIT_SN_DATA];
    end
endmodule

// File: rtl/gpio_ports.sv
module gpio_ports
    import gpio_ports_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 32,
    parameter int WIN_BYTES = 92
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              flash_ready,
    output logic              flash_ale,
    output logic              flash_cle,
    output logic              flash_ce,
    input  logic              sens_sdo,
    output logic              sens_edge,
    output logic              sens_clk,
    output logic              sens_sdi
);
    localparam int NUM_WORDS = WIN_BYTES / 4;
    localparam int IDX_W     = ADDR_W - 2;

    logic [IDX_W-1:0]                 idx;
    logic [NUM_WORDS-1:0][DATA_W-1:0] words;

    assign idx = bus_addr[ADDR_W-1:2];

    gpio_word_bank #(.DATA_W(DATA_W), .NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (bus_wr),
        .idx   (idx),
        .wdata (bus_wdata),
        .words (words)
    );

    gpio_read_mux #(.DATA_W(DATA_W), .NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W)) u_rmux (
        .idx      (idx),
        .words    (words),
        .fl_ready (flash_ready),
        .sn_sdo   (sens_sdo),
        .rdata    (bus_rdata)
    );

    gpio_periph_map #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_pmap (
        .wr      (bus_wr),
        .idx     (idx),
        .wdata   (bus_wdata),
        .a_dout  (words[IDX_A_DOUT]),
        .d_dout  (words[IDX_D_DOUT]),
        .fl_ale  (flash_ale),
        .fl_cle  (flash_cle),
        .fl_ce   (flash_ce),
        .sn_edge (sens_edge),
        .sn_clk  (sens_clk),
        .sn_sdi  (sens_sdi)
    );
endmodule

// File: rtl/gpio_ports_chk.sv
module gpio_ports_chk #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              flash_ready,
    input logic              flash_ale,
    input logic              flash_cle,
    input logic              flash_ce,
    input logic              sens_sdo,
    input logic              sens_edge,
    input logic              sens_clk,
    input logic              sens_sdi
);
    logic [ADDR_W-3:0] w_idx;
    logic              d_wr;
    logic              clk_shadow;

    assign w_idx = bus_addr[ADDR_W-1:2];
    assign d_wr  = bus_wr && (w_idx == (ADDR_W-2)'('h10));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) clk_shadow <= 1'b0;
        else if (d_wr) clk_shadow <= bus_wdata[1];
    end

    p_reset_strobes_r1: assert property (@(posedge clk)
        !rst_n |=> (!flash_ale && !flash_cle && !flash_ce));

    p_out_of_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (w_idx >= (ADDR_W-2)'(23)) |-> (bus_rdata == '0));

    p_ready_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (w_idx == (ADDR_W-2)'('h01) && flash_ready) |-> bus_rdata[7]);

    p_sdo_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (w_idx == (ADDR_W-2)'('h11) && sens_sdo) |-> bus_rdata[4]);

    p_strobes_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && w_idx == '0) |=>
            (flash_ale == $past(bus_wdata[6]) && flash_cle == $past(bus_wdata[5])
             && flash_ce == $past(bus_wdata[4])));

    p_edge_fires_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (d_wr && bus_wdata[1] != clk_shadow) |->
            (sens_edge && sens_clk == bus_wdata[1] && sens_sdi == bus_wdata[4]));

    p_edge_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(d_wr && bus_wdata[1] != clk_shadow) |-> (!sens_edge && !sens_clk && !sens_sdi));
endmodule

bind gpio_ports gpio_ports_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_wr      (bus_wr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .flash_ready (flash_ready),
    .flash_ale   (flash_ale),
    .flash_cle   (flash_cle),
    .flash_ce    (flash_ce),
    .sens_sdo    (sens_sdo),
    .sens_edge   (sens_edge),
    .sens_clk    (sens_clk),
    .sens_sdi    (sens_sdi)
);

// File: tb/gpio_ports_test.sv
`timescale 1ns/1ps
module gpio_ports_test;
    localparam int NW = 23;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        flash_ready = 1'b0;
    logic        flash_ale, flash_cle, flash_ce;
    logic        sens_sdo = 1'b0;
    logic        sens_edge, sens_clk, sens_sdi;

    int checks = 0;
    int errors = 0;
    logic [31:0] model [NW];
    int unsigned seed_dummy;

    always #10 clk = ~clk; // 50 MHz

    gpio_ports uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .flash_ready(flash_ready),
        .flash_ale(flash_ale), .flash_cle(flash_cle), .flash_ce(flash_ce),
        .sens_sdo(sens_sdo), .sens_edge(sens_edge), .sens_clk(sens_clk),
        .sens_sdi(sens_sdi)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(input int idx);
        logic [31:0] r;
        if (idx >= NW) return '0;
        if (idx == 'h01) begin
            r = model['h00] & model['h02];
            r[7] = r[7] | flash_ready;
            return r;
        end
        if (idx == 'h11) begin
            r = model['h10] & model['h12];
            r[4] = r[4] | sens_sdo;
            return r;
        end
        return model[idx];
    endfunction

    task automatic do_read(input int idx, input string req);
        @(negedge clk);
        bus_wr   = 1'b0;
        bus_addr = 8'((idx << 2) | ($urandom % 4));
        #1;
        chk(bus_rdata == exp_read(idx), req, bus_rdata, exp_read(idx));
        chk(!sens_edge, "R9", 32'(sens_edge), 32'd0);
    endtask

    task automatic do_write(input int idx, input logic [31:0] data);
        bit exp_edge;
        @(negedge clk);
        bus_wr    = 1'b1;
        bus_addr  = 8'((idx << 2) | ($urandom % 4));
        bus_wdata = data;
        #1;
        exp_edge = (idx == 'h10) && (data[1] != model['h10][1]);
        if (exp_edge) begin
            chk(sens_edge == 1'b1, "R8", 32'(sens_edge), 32'd1);
            chk(sens_clk == data[1], "R8", 32'(sens_clk), 32'(data[1]));
            chk(sens_sdi == data[4], "R8", 32'(sens_sdi), 32'(data[4]));
        end else begin
            chk({sens_edge, sens_clk, sens_sdi} == 3'b000, "R9",
                32'({sens_edge, sens_clk, sens_sdi}), 32'd0);
        end
        @(posedge clk);
        if (idx < NW && idx != 'h01 && idx != 'h11) model[idx] = data;
        #1;
        bus_wr = 1'b0;
    endtask

    task automatic chk_strobes();
        @(negedge clk);
        #1;
        chk({flash_ale, flash_cle, flash_ce} == {model[0][6], model[0][5], model[0][4]},
            "R7", 32'({flash_ale, flash_cle, flash_ce}),
            32'({model[0][6], model[0][5], model[0][4]}));
    endtask

    initial begin
        seed_dummy = $urandom(32'h5eed_1234);
        for (int i = 0; i < NW; i++) model[i] = '0;
        repeat (3) @(posedge clk);
        #1;
        chk({flash_ale, flash_cle, flash_ce} == 3'b000, "R1",
            32'({flash_ale, flash_cle, flash_ce}), 32'd0);
        rst_n = 1'b1;
        // R1: every word reads zero after reset
        for (int i = 0; i < NW; i++) do_read(i, "R1");
        chk_strobes();

        // R2: plain storage
        do_write(5, 32'hDEAD_BEEF);
        do_read(5, "R2");
        do_write(22, 32'h1234_5678);
        do_read(22, "R2");
        // R3: outside the window
        do_write(23, 32'hFFFF_FFFF);
        do_read(23, "R3");
        do_write(63, 32'hA5A5_A5A5);
        do_read(63, "R3");
        do_read(22, "R3");
        // R4: port A data-in
        do_write('h00, 32'hF0F0_00F0);
        do_write('h02, 32'hFF00_FF70);
        flash_ready = 1'b1;
        do_read('h01, "R4");
        flash_ready = 1'b0;
        do_read('h01, "R4");
        chk_strobes(); // R7
        // R6: data-in writes ignored
        do_write('h01, 32'hFFFF_FFFF);
        do_read('h01, "R6");
        do_write('h11, 32'hFFFF_FFFF);
        do_read('h11, "R6");
        // R5: port D data-in
        do_write('h12, 32'h0000_FFEF);
        sens_sdo = 1'b1;
        do_read('h11, "R5");
        // R8/R9: clock toggles and same-level writes
        do_write('h10, 32'h0000_0012); // rise, data 1
        do_write('h10, 32'h0000_0002); // same level
        do_read('h10, "R9");
        do_write('h10, 32'h0000_0010); // fall
        do_write('h10, 32'h0000_0000); // same level
        do_read('h11, "R5");
        sens_sdo = 1'b0;

        // constrained random traffic
        for (int n = 0; n < 400; n++) begin
            int idx;
            int kind;
            kind = int'($urandom % 8);
            if (kind < 3) idx = int'($urandom % 3);
            else if (kind < 6) idx = 'h10 + int'($urandom % 3);
            else idx = int'($urandom % 28);
            flash_ready = 1'($urandom);
            sens_sdo    = 1'($urandom);
            if ($urandom % 2 == 0) begin
                do_write(idx, $urandom);
                if (idx == 0) chk_strobes();
            end else begin
                do_read(idx, "R2");
            end
        end
        do_read('h01, "R4");
        do_read('h11, "R5");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule